// File: doc/BRIEF.md
# Reset-Cause and Processor Status Register

This block is the 8-bit status and control register of a small microcontroller core. It keeps sticky flags that tell firmware why the last reset happened. A power-on or low-voltage/brown-out reset and a watchdog rollover each leave a different pattern behind, so a reset handler can tell them apart. The register also latches a bus activity event once it has stayed active for a qualification window. It mirrors the core's interrupt-pending and interrupt-enable state, and it holds the suspend and run controls that stop the core.

The core drives reset-kind strobes, instruction strobes and interrupt levels into the block. Firmware reads the register through `status_o` and writes it through `wr_en`/`wr_data`. The bus event is qualified against a free-running prescaled tick of `TICK_CYCLES` clocks, which nominally represents 128 µs. An event therefore qualifies after between one and two tick periods of uninterrupted activity.

Top module: `proc_status_reg`

## Requirements
- R1: A synchronous `rst` or an `lvr_evt` pulse loads the register with 0x11 (power flag bit 4 and run bit 0 set, all other bits clear) and restarts the tick prescaler and the bus qualifier; it takes priority over every other input.
- R2: A `wdt_evt` pulse (without R1 reset) sets bit 6 and run bit 0, keeps bit 4 unchanged, and clears bits 7, 5, 3 and 2; it also restarts the prescaler and qualifier.
- R3: A firmware write can only clear bits 6, 5 and 4: a 0 in that `wr_data` position clears the bit, a 1 leaves it as it was.
- R4: The selected event is `usb_reset_lvl` when `bus_mode` is 0 and `ps2_act_lvl` when it is 1. Bit 5 sets at the second prescaler tick seen while that event stays continuously active. Any inactive cycle restarts the count. The unselected input has no effect.
- R5: Once set, bit 5 stays set after the event ends. A qualification in the same cycle as a firmware clear of bit 5 leaves it set.
- R6: Writing 1 to bit 3 sets suspend (`suspend_o`); writing 0 there has no effect. While bit 3 is 1, `wake_req` clears it on the next edge. A write of 1 with `wake_req` already active still shows bit 3 set for one cycle before it clears.
- R7: Bit 2 is set by `ei_stb`, cleared by `di_stb` and loaded from `reti_ie` by `reti_stb`, with priority DI over EI over RETI. Firmware writes to bit 2 have no effect.
- R8: `halt_stb` clears run bit 0 (`run_o`). A firmware write loads bit 0 from `wr_data[0]`. A halt wins over a simultaneous write. Resets of R1 and R2 set the bit.
- R9: Bit 7 shows, one cycle later, `irq_pend` masked by `irq_ack`; it is 0 in any cycle after `irq_ack` is high.
- R10: Bit 1 always reads 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| lvr_evt | input | 1 | Low-voltage or brown-out reset strobe |
| wdt_evt | input | 1 | Watchdog rollover reset strobe |
| bus_mode | input | 1 | Event source select: 0 USB bus reset, 1 PS/2 activity |
| usb_reset_lvl | input | 1 | USB bus reset condition level |
| ps2_act_lvl | input | 1 | PS/2 activity level |
| irq_pend | input | 1 | Any interrupt pending in the core |
| irq_ack | input | 1 | Interrupt accepted by the handling sequence |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| reti_ie | input | 1 | Enable state restored by the return |
| halt_stb | input | 1 | Halt instruction strobe |
| wake_req | input | 1 | Resume condition from suspend |
| wr_en | input | 1 | Firmware register write |
| wr_data | input | 8 | Firmware write data |
| status_o | output | 8 | Register contents |
| suspend_o | output | 1 | Suspend control to the core |
| run_o | output | 1 | Run control to the core |

## Verification
The bench builds the block with `TICK_CYCLES` = 8 instead of the default 6144. A bus event therefore qualifies within 9 to 16 cycles. Both the sub-window pulse trains and the steady events that cross two ticks fit into short directed sequences. With the shortened tick, a long random phase also sees many qualifications. Those qualifications collide with firmware clears, resets and mode flips often enough to reach the R5 priority case and the qualifier restarts.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned B_IRQ  = 7;
  localparam int unsigned B_WDR  = 6;
  localparam int unsigned B_BUS  = 5;
  localparam int unsigned B_PWR  = 4;
  localparam int unsigned B_SUSP = 3;
  localparam int unsigned B_IE   = 2;
  localparam int unsigned B_RSV  = 1;
  localparam int unsigned B_RUN  = 0;
  localparam logic [REG_W-1:0] PWR_VALUE = 8'h11;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_WDT  = 2'd1,
    RK_PWR  = 2'd2
  } reset_kind_e;
endpackage

// File: rtl/psr_tick_gen.sv
module psr_tick_gen #(
  parameter int unsigned TICK_CYCLES = 6144
) (
  input  logic clk,
  input  logic clr,
  output logic tick_o
);
  localparam int unsigned PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (clr)                pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == LAST);

  generate
    if (TICK_CYCLES > 1) begin : g_spacing
      // R4: ticks never come on consecutive cycles
      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (clr)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/psr_bus_qual.sv
module psr_bus_qual (
  input  logic clk,
  input  logic clr,
  input  logic mode,
  input  logic usb_lvl,
  input  logic ps2_lvl,
  input  logic tick,
  output logic hit_o
);
  logic       evt;
  logic [1:0] cnt_q;

  assign evt = mode ? ps2_lvl : usb_lvl;

  always_ff @(posedge clk) begin
    if (clr || !evt)                  cnt_q <= 2'd0;
    else if (tick && cnt_q != 2'd2)   cnt_q <= cnt_q + 2'd1;
  end

  assign hit_o = evt && tick && (cnt_q == 2'd1);

  // R4: a non-zero count only exists after an active selected event
  a_r4_count_needs_event: assert property (@(posedge clk) disable iff (clr)
    (cnt_q != 2'd0) |-> $past(mode ? ps2_lvl : usb_lvl));
  // R4: an inactive event restarts the count
  a_r4_idle_restarts: assert property (@(posedge clk) disable iff (clr)
    !(mode ? ps2_lvl : usb_lvl) |=> (cnt_q == 2'd0));
endmodule

// File: rtl/psr_ctrl_bits.sv
module psr_ctrl_bits (
  input  logic clk,
  input  logic load_rst,
  input  logic wr_en,
  input  logic wr_susp,
  input  logic wr_run,
  input  logic wake,
  input  logic ei,
  input  logic di,
  input  logic reti,
  input  logic reti_ie,
  input  logic halt,
  output logic susp_o,
  output logic ie_o,
  output logic run_o
);
  always_ff @(posedge clk) begin
    if (load_rst) begin
      susp_o <= 1'b0;
      ie_o   <= 1'b0;
      run_o  <= 1'b1;
    end else begin
      if (wr_en && wr_susp) susp_o <= 1'b1;
      else if (susp_o && wake) susp_o <= 1'b0;

      if (di)        ie_o <= 1'b0;
      else if (ei)   ie_o <= 1'b1;
      else if (reti) ie_o <= reti_ie;

      if (halt)       run_o <= 1'b0;
      else if (wr_en) run_o <= wr_run;
    end
  end

  // R6: wake ends suspend unless a new request arrives
  a_r6_wake_clears: assert property (@(posedge clk) disable iff (load_rst)
    (susp_o && wake && !(wr_en && wr_susp)) |=> !susp_o);
  // R6: a write of 1 always enters suspend, even with wake present
  a_r6_write_enters: assert property (@(posedge clk) disable iff (load_rst)
    (wr_en && wr_susp) |=> susp_o);
  // R7: DI has priority
  a_r7_di_wins: assert property (@(posedge clk) disable iff (load_rst)
    di |=> !ie_o);
  // R8: halt wins over a write
  a_r8_halt_stops: assert property (@(posedge clk) disable iff (load_rst)
    halt |=> !run_o);
endmodule

// File: rtl/proc_status_reg.sv
module proc_status_reg
  import psr_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 6144
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvr_evt,
  input  logic             wdt_evt,
  input  logic             bus_mode,
  input  logic             usb_reset_lvl,
  input  logic             ps2_act_lvl,
  input  logic             irq_pend,
  input  logic             irq_ack,
  input  logic             ei_stb,
  input  logic             di_stb,
  input  logic             reti_stb,
  input  logic             reti_ie,
  input  logic             halt_stb,
  input  logic             wake_req,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] status_o,
  output logic             suspend_o,
  output logic             run_o
);
  reset_kind_e rkind;
  logic any_rst, tick, bus_hit;
  logic irq_q, wdr_q, bus_q, pwr_q;
  logic susp_b, ie_b, run_b;
  logic unused_wr;

  always_comb begin
    if (rst || lvr_evt) rkind = RK_PWR;
    else if (wdt_evt)   rkind = RK_WDT;
    else                rkind = RK_NONE;
  end
  assign any_rst   = (rkind != RK_NONE);
  assign unused_wr = ^{wr_data[B_IRQ], wr_data[B_IE], wr_data[B_RSV]};

  psr_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .clr(any_rst), .tick_o(tick)
  );

  psr_bus_qual u_qual (
    .clk(clk), .clr(any_rst), .mode(bus_mode), .usb_lvl(usb_reset_lvl),
    .ps2_lvl(ps2_act_lvl), .tick(tick), .hit_o(bus_hit)
  );

  psr_ctrl_bits u_ctrl (
    .clk(clk), .load_rst(any_rst), .wr_en(wr_en), .wr_susp(wr_data[B_SUSP]),
    .wr_run(wr_data[B_RUN]), .wake(wake_req), .ei(ei_stb), .di(di_stb),
    .reti(reti_stb), .reti_ie(reti_ie), .halt(halt_stb),
    .susp_o(susp_b), .ie_o(ie_b), .run_o(run_b)
  );

  always_ff @(posedge clk) begin
    unique case (rkind)
      RK_PWR: begin
        irq_q <= 1'b0;
        wdr_q <= 1'b0;
        bus_q <= 1'b0;
        pwr_q <= 1'b1;
      end
      RK_WDT: begin
        irq_q <= 1'b0;
        wdr_q <= 1'b1;
        bus_q <= 1'b0;
      end
      default: begin
        irq_q <= irq_pend && !irq_ack;
        if (wr_en) begin
          wdr_q <= wdr_q & wr_data[B_WDR];
          pwr_q <= pwr_q & wr_data[B_PWR];
        end
        if (bus_hit)    bus_q <= 1'b1;
        else if (wr_en) bus_q <= bus_q & wr_data[B_BUS];
      end
    endcase
  end

  always_comb begin
    status_o         = '0;
    status_o[B_IRQ]  = irq_q;
    status_o[B_WDR]  = wdr_q;
    status_o[B_BUS]  = bus_q;
    status_o[B_PWR]  = pwr_q;
    status_o[B_SUSP] = susp_b;
    status_o[B_IE]   = ie_b;
    status_o[B_RUN]  = run_b;
  end
  assign suspend_o = susp_b;
  assign run_o     = run_b;

  // R1: power-class reset loads the fixed pattern
  a_r1_pwr_value: assert property (@(posedge clk)
    (rst || lvr_evt) |=> (status_o == PWR_VALUE));
  // R2: watchdog keeps the power flag and sets its own
  a_r2_wdt_flags: assert property (@(posedge clk) disable iff (rst || lvr_evt)
    wdt_evt |=> (status_o[B_WDR] && status_o[B_RUN]
                 && status_o[B_PWR] == $past(status_o[B_PWR])));
  // R3: a write never sets a cause bit
  a_r3_clear_only: assert property (@(posedge clk) disable iff (any_rst)
    (wr_en && !status_o[B_WDR]) |=> !status_o[B_WDR]);
  // R5: qualification wins over a firmware clear
  a_r5_hit_sets: assert property (@(posedge clk) disable iff (any_rst)
    bus_hit |=> status_o[B_BUS]);
  // R9: an acknowledge drops the pending flag
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !status_o[B_IRQ]);
endmodule

// File: tb/test_proc_status_reg.sv
module test_proc_status_reg;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst = 1'b1, lvr_evt = 0, wdt_evt = 0, bus_mode = 0;
  logic usb_reset_lvl = 0, ps2_act_lvl = 0, irq_pend = 0, irq_ack = 0;
  logic ei_stb = 0, di_stb = 0, reti_stb = 0, reti_ie = 0, halt_stb = 0;
  logic wake_req = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] status_o;
  logic suspend_o, run_o;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit model_on = 0;
  logic [7:0] m = 8'h00;
  int m_pre = 0, m_cnt = 0;

  always #4 clk = ~clk;

  proc_status_reg #(.TICK_CYCLES(T)) i_proc_status_reg (
    .clk(clk), .rst(rst), .lvr_evt(lvr_evt), .wdt_evt(wdt_evt),
    .bus_mode(bus_mode), .usb_reset_lvl(usb_reset_lvl), .ps2_act_lvl(ps2_act_lvl),
    .irq_pend(irq_pend), .irq_ack(irq_ack), .ei_stb(ei_stb), .di_stb(di_stb),
    .reti_stb(reti_stb), .reti_ie(reti_ie), .halt_stb(halt_stb),
    .wake_req(wake_req), .wr_en(wr_en), .wr_data(wr_data),
    .status_o(status_o), .suspend_o(suspend_o), .run_o(run_o)
  );

  // behavioural reference of the register
  always @(posedge clk) begin
    bit evt, tk, hit;
    logic [7:0] nm;
    evt = bus_mode ? ps2_act_lvl : usb_reset_lvl;
    tk  = (m_pre == T - 1);
    hit = evt && tk && (m_cnt == 1);
    if (rst || lvr_evt) begin
      m = 8'h11; m_pre = 0; m_cnt = 0;
    end else if (wdt_evt) begin
      m = {3'b010, m[4], 4'b0001}; m_pre = 0; m_cnt = 0;
    end else begin
      nm = m;
      nm[7] = irq_pend && !irq_ack;
      if (wr_en) begin
        nm[6] = m[6] & wr_data[6];
        nm[5] = m[5] & wr_data[5];
        nm[4] = m[4] & wr_data[4];
      end
      if (hit) nm[5] = 1'b1;
      if (wr_en && wr_data[3]) nm[3] = 1'b1;
      else if (m[3] && wake_req) nm[3] = 1'b0;
      if (di_stb) nm[2] = 1'b0;
      else if (ei_stb) nm[2] = 1'b1;
      else if (reti_stb) nm[2] = reti_ie;
      if (halt_stb) nm[0] = 1'b0;
      else if (wr_en) nm[0] = wr_data[0];
      nm[1] = 1'b0;
      m_pre = tk ? 0 : m_pre + 1;
      if (!evt) m_cnt = 0;
      else if (tk && m_cnt < 2) m_cnt = m_cnt + 1;
      m = nm;
    end
  end

  function automatic string req_of(int b);
    case (b)
      7: return "R9"; 6: return "R2"; 5: return "R4"; 4: return "R1";
      3: return "R6"; 2: return "R7"; 1: return "R10"; default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic compare_model();
    n_chk++;
    if (status_o !== m || suspend_o !== m[3] || run_o !== m[0]) begin
      string r = "R6";
      for (int b = 7; b >= 0; b--) if (status_o[b] !== m[b]) r = req_of(b);
      n_fail++;
      $display("FAIL %s model: actual %02h/%b/%b expected %02h/%b/%b", r,
               status_o, suspend_o, run_o, m, m[3], m[0]);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      if (model_on) compare_model();
    end
  endtask

  task automatic idle();
    rst = 0; lvr_evt = 0; wdt_evt = 0; irq_ack = 0;
    ei_stb = 0; di_stb = 0; reti_stb = 0; halt_stb = 0; wr_en = 0;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d; cyc(); wr_en = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not end");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    idle(); model_on = 1;
    cyc(); chk("R1 reset value", status_o, 8'h11);
    wr(8'hFF); chk("R3 R10 R7 write ones", status_o, 8'h19);
    chk("R6 suspend out", {7'd0, suspend_o}, 8'h01);
    wake_req = 1; cyc(); wake_req = 0; chk("R6 wake clears", status_o, 8'h11);
    wr(8'h01); chk("R3 clear power flag", status_o, 8'h01);
    wdt_evt = 1; cyc(); idle(); chk("R2 watchdog", status_o, 8'h41);
    lvr_evt = 1; cyc(); idle(); chk("R1 low voltage", status_o, 8'h11);
    wdt_evt = 1; cyc(); idle(); chk("R2 watchdog after power", status_o, 8'h51);
    ei_stb = 1; cyc(); idle(); chk("R7 EI", status_o, 8'h55);
    ei_stb = 1; di_stb = 1; cyc(); idle(); chk("R7 DI wins", status_o, 8'h51);
    reti_stb = 1; reti_ie = 1; cyc(); idle(); chk("R7 RETI", status_o, 8'h55);
    wr(8'h50); chk("R8 R7 write run 0", status_o, 8'h54);
    chk("R8 run out", {7'd0, run_o}, 8'h00);
    wr(8'h51); chk("R8 write run 1", status_o, 8'h55);
    halt_stb = 1; wr(8'h51); idle(); chk("R8 halt wins", status_o, 8'h54);
    wdt_evt = 1; cyc(); idle(); chk("R8 watchdog restarts", status_o, 8'h51);
    wr(8'h01);
    usb_reset_lvl = 1; cyc(3 * T); chk("R4 usb event", status_o, 8'h21);
    usb_reset_lvl = 0; cyc(3 * T); chk("R5 persists", status_o, 8'h21);
    wr(8'h01); chk("R3 clear bus flag", status_o, 8'h01);
    bus_mode = 1;
    for (int k = 0; k < 6; k++) begin
      ps2_act_lvl = 1; cyc(T - 1); ps2_act_lvl = 0; cyc();
    end
    chk("R4 short bursts", status_o, 8'h01);
    usb_reset_lvl = 1; cyc(3 * T); usb_reset_lvl = 0;
    chk("R4 unselected ignored", status_o, 8'h01);
    ps2_act_lvl = 1; cyc(3 * T); ps2_act_lvl = 0;
    chk("R4 ps2 event", status_o, 8'h21);
    wake_req = 1; wr(8'h29); chk("R6 enter with wake", status_o, 8'h29);
    cyc(); wake_req = 0; chk("R6 immediate wake", status_o, 8'h21);
    wr(8'h29); wr(8'h21); chk("R6 write 0 ignored", status_o, 8'h29);
    wake_req = 1; cyc(); wake_req = 0; chk("R6 resume", status_o, 8'h21);
    irq_pend = 1; cyc(); chk("R9 pending", status_o, 8'hA1);
    irq_ack = 1; cyc(); chk("R9 accepted", status_o, 8'h21);
    irq_ack = 0; irq_pend = 0; cyc();
    for (int i = 0; i < 4000; i++) begin
      rst      = ($urandom_range(499) == 0);
      lvr_evt  = ($urandom_range(399) == 0);
      wdt_evt  = ($urandom_range(299) == 0);
      if ($urandom_range(199) == 0) bus_mode = ~bus_mode;
      if ($urandom_range(11) == 0) usb_reset_lvl = ~usb_reset_lvl;
      if ($urandom_range(11) == 0) ps2_act_lvl = ~ps2_act_lvl;
      irq_pend = $urandom_range(1);
      irq_ack  = ($urandom_range(3) == 0);
      ei_stb   = ($urandom_range(9) == 0);
      di_stb   = ($urandom_range(9) == 0);
      reti_stb = ($urandom_range(9) == 0);
      reti_ie  = $urandom_range(1);
      halt_stb = ($urandom_range(49) == 0);
      wake_req = ($urandom_range(7) == 0);
      wr_en    = ($urandom_range(9) == 0);
      wr_data  = 8'($urandom_range(255));
      cyc();
    end
    idle(); cyc();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule